// File: doc/BRIEF.md
# Load-Use Stall and Decode-Branch Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline and handles the two hazards that operand forwarding cannot cover. The first is a load in execute whose destination register is a source of the instruction now in decode. In that case the controller freezes the program counter and the fetch/decode pipeline register for one cycle. It also tells the decode stage to push a bubble, a no-op with all controls cleared, into the decode/execute register.

The second hazard is a conditional branch. Branches are predicted not taken, and the outcome is settled in decode by testing the two register read values for equality. When a branch is taken, the controller raises a fetch-flush that clears the fetch/decode register, which discards the one wrongly fetched instruction. It also switches the program-counter source to the branch target. The target is computed here as the incremented PC plus the sign-extended word offset shifted left by two.

All outputs are combinational functions of the present inputs. The pipeline registers around the block supply the sequencing. The clock and reset inputs serve only the embedded property checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_rt` is nonzero and `ex_rt` equals `id_rs` or `id_rt`, and no taken branch is present, the outputs are `pc_write`=0, `ifid_write`=0 and `bubble_sel`=1.
- R2: When `ex_mem_read` is 0, or `ex_rt` matches neither `id_rs` nor `id_rt`, there is no stall: `pc_write`=1, `ifid_write`=1 and `bubble_sel`=0.
- R3: When `ex_rt` is 0 (the hard-wired zero register), a load never causes a stall, even if `id_rs` or `id_rt` is also 0.
- R4: When `id_branch` is 1 and `id_rdata_a` equals `id_rdata_b`, the branch is taken: `fetch_flush`=1 and `pc_src`=1 (1 selects the branch target, 0 selects the sequential PC).
- R5: When `id_branch` is 0 or the two operands differ, the not-taken prediction stands: `fetch_flush`=0 and `pc_src`=0.
- R6: `branch_target` equals `id_pc_incr` plus the 16-bit `id_offset`, sign-extended and multiplied by 4, modulo 2^32. Negative offsets point backward.
- R7: When a taken branch and a load-use hazard occur in the same cycle, the flush wins: `fetch_flush`=1, `pc_src`=1, `pc_write`=1, `ifid_write`=1 and `bubble_sel`=0.
- R8: With no load in execute and no branch in decode, the outputs are `pc_write`=1, `ifid_write`=1, `bubble_sel`=0, `fetch_flush`=0 and `pc_src`=0.
- R9: The block holds no state. A stall is asserted in exactly the cycles in which the hazard condition is present at the inputs. A load followed by a dependent instruction therefore costs one bubble cycle, because the bubble clears `ex_mem_read` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded properties |
| rst_n | input | 1 | Active-low reset that disables the properties |
| ex_mem_read | input | 1 | The instruction in execute reads data memory (is a load) |
| ex_rt | input | 5 | Destination register of the instruction in execute |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second source register of the instruction in decode |
| id_branch | input | 1 | The instruction in decode is a branch-on-equal |
| id_rdata_a | input | 32 | First register read value in decode |
| id_rdata_b | input | 32 | Second register read value in decode |
| id_pc_incr | input | 32 | Incremented PC of the instruction in decode |
| id_offset | input | 16 | Branch offset field in words |
| pc_write | output | 1 | Enable for the PC register |
| ifid_write | output | 1 | Enable for the fetch/decode register |
| bubble_sel | output | 1 | Selects all-zero controls into decode/execute |
| fetch_flush | output | 1 | Clears the fetch/decode register |
| pc_src | output | 1 | PC source: 0 sequential, 1 branch target |
| branch_target | output | 32 | Computed branch destination |

## Verification
Every result of this controller is due in the same cycle as its stimulus, since there is no register between the inputs and any output. The bench therefore changes the inputs on the falling clock edge and compares the outputs a few nanoseconds later, before the next rising edge. For the one-bubble rule, the bench applies a load-use pattern for one cycle and then supplies the cleared execute controls that the bubble produces. It checks that the stall appears in the first cycle and is gone in the following one. A hazard held for two cycles must stall in both of them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {
    PC_SEQ    = 1'b0,
    PC_BRANCH = 1'b1
  } pc_sel_e;

  typedef struct packed {
    logic    pc_we;
    logic    ifid_we;
    logic    bubble;
    logic    flush;
    pc_sel_e sel;
  } hzd_ctl_t;
endpackage

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_in_ex,
  input  logic [REG_AW-1:0] ld_dst,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live;
  logic match_a;
  logic match_b;

  always_comb begin
    dst_live = (ld_dst != ZERO_REG);
    match_a  = (ld_dst == src_a);
    match_b  = (ld_dst == src_b);
    hit      = ld_in_ex & dst_live & (match_a | match_b);
  end

  // R3: a load targeting the zero register never reports a hazard
  a_r3_zero_dst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_dst == ZERO_REG) |-> !hit);

  // R2: without a load in execute no hazard is reported
  a_r2_no_load_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_in_ex |-> !hit);
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int OFFS_W = 16
) (
  input  logic              is_branch,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [PC_W-1:0]   pc_incr,
  input  logic [OFFS_W-1:0] offset,
  output logic              taken,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - OFFS_W - 2;

  logic [PC_W-1:0] byte_disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_disp = {{EXT_W{offset[OFFS_W-1]}}, offset, 2'b00};
    end else begin : g_trunc
      logic [OFFS_W+1:0] wide_disp;
      assign wide_disp = {offset, 2'b00};
      assign byte_disp = wide_disp[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    taken  = is_branch & (opnd_a == opnd_b);
    target = pc_incr + byte_disp;
  end
endmodule

// File: rtl/hazard_arbiter.sv
module hazard_arbiter
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lu_hit,
  input  logic     br_taken,
  output hzd_ctl_t ctl
);
  logic hold;

  always_comb begin
    hold        = lu_hit & ~br_taken;
    ctl.pc_we   = ~hold;
    ctl.ifid_we = ~hold;
    ctl.bubble  = hold;
    ctl.flush   = br_taken;
    ctl.sel     = br_taken ? PC_BRANCH : PC_SEQ;
  end

  // R1: a stall freezes PC and the fetch/decode register and injects a bubble
  a_r1_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_hit && !br_taken) |-> (!ctl.pc_we && !ctl.ifid_we && ctl.bubble));

  // R4: a taken branch flushes fetch and redirects the PC
  a_r4_taken_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (ctl.flush && ctl.sel == PC_BRANCH));

  // R7: flush wins over stall
  a_r7_flush_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |-> (ctl.pc_we && ctl.ifid_we && !ctl.bubble));

  // R9: the two write enables always move together
  a_r9_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_we == ctl.ifid_we);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_branch,
  input  logic [DATA_W-1:0] id_rdata_a,
  input  logic [DATA_W-1:0] id_rdata_b,
  input  logic [PC_W-1:0]   id_pc_incr,
  input  logic [OFFS_W-1:0] id_offset,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              bubble_sel,
  output logic              fetch_flush,
  output logic              pc_src,
  output logic [PC_W-1:0]   branch_target
);
  logic     lu_hit;
  logic     br_taken;
  hzd_ctl_t ctl;

  load_use_detect #(.REG_AW(REG_AW)) i_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_in_ex (ex_mem_read),
    .ld_dst   (ex_rt),
    .src_a    (id_rs),
    .src_b    (id_rt),
    .hit      (lu_hit)
  );

  branch_resolve #(.DATA_W(DATA_W), .PC_W(PC_W), .OFFS_W(OFFS_W)) i_branch (
    .is_branch (id_branch),
    .opnd_a    (id_rdata_a),
    .opnd_b    (id_rdata_b),
    .pc_incr   (id_pc_incr),
    .offset    (id_offset),
    .taken     (br_taken),
    .target    (branch_target)
  );

  hazard_arbiter i_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lu_hit   (lu_hit),
    .br_taken (br_taken),
    .ctl      (ctl)
  );

  assign pc_write    = ctl.pc_we;
  assign ifid_write  = ctl.ifid_we;
  assign bubble_sel  = ctl.bubble;
  assign fetch_flush = ctl.flush;
  assign pc_src      = (ctl.sel == PC_BRANCH);

  // R5: without a branch in decode the PC stays sequential
  a_r5_no_branch_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !id_branch |-> (!fetch_flush && !pc_src));

  // R6: the target is stable while its operands are stable
  a_r6_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(id_pc_incr) && $stable(id_offset)) |-> $stable(branch_target));
endmodule

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
  logic        clk;
  logic        rst_n;
  logic        ex_mem_read;
  logic [4:0]  ex_rt, id_rs, id_rt;
  logic        id_branch;
  logic [31:0] id_rdata_a, id_rdata_b, id_pc_incr;
  logic [15:0] id_offset;
  logic        pc_write, ifid_write, bubble_sel, fetch_flush, pc_src;
  logic [31:0] branch_target;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  pipe_hazard_ctrl i_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .ex_mem_read(ex_mem_read), .ex_rt(ex_rt),
    .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
    .id_rdata_a(id_rdata_a), .id_rdata_b(id_rdata_b),
    .id_pc_incr(id_pc_incr), .id_offset(id_offset),
    .pc_write(pc_write), .ifid_write(ifid_write), .bubble_sel(bubble_sel),
    .fetch_flush(fetch_flush), .pc_src(pc_src), .branch_target(branch_target)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic mr, input logic [4:0] rt_ex, input logic [4:0] rs,
                       input logic [4:0] rt, input logic br,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    ex_mem_read = mr; ex_rt = rt_ex; id_rs = rs; id_rt = rt;
    id_branch = br; id_rdata_a = a; id_rdata_b = b;
    #2;
  endtask

  // expected control vector {pc_write, ifid_write, bubble_sel, fetch_flush, pc_src}
  task automatic chk_ctl(input string req, input logic [4:0] exp);
    chk(req, {27'd0, pc_write, ifid_write, bubble_sel, fetch_flush, pc_src}, {27'd0, exp});
  endtask

  task automatic t_reset;
    drive(0, 0, 0, 0, 0, 0, 1);
    chk_ctl("R8 idle outputs in reset", 5'b11000);
  endtask

  task automatic t_load_use;
    drive(1, 5'd7, 5'd7, 5'd3, 0, 1, 2);
    chk_ctl("R1 stall on rs match", 5'b00100);
    drive(1, 5'd9, 5'd4, 5'd9, 0, 1, 2);
    chk_ctl("R1 stall on rt match", 5'b00100);
  endtask

  task automatic t_no_hazard;
    drive(0, 5'd7, 5'd7, 5'd7, 0, 1, 2);
    chk_ctl("R2 no load no stall", 5'b11000);
    drive(1, 5'd8, 5'd4, 5'd5, 0, 1, 2);
    chk_ctl("R2 load unrelated regs", 5'b11000);
  endtask

  task automatic t_zero_reg;
    drive(1, 5'd0, 5'd0, 5'd0, 0, 1, 2);
    chk_ctl("R3 zero destination ignored", 5'b11000);
  endtask

  task automatic t_branch;
    drive(0, 0, 5'd1, 5'd2, 1, 32'hDEAD0001, 32'hDEAD0001);
    chk_ctl("R4 taken branch", 5'b11011);
    drive(0, 0, 5'd1, 5'd2, 1, 32'hDEAD0001, 32'hDEAD0002);
    chk_ctl("R5 unequal operands", 5'b11000);
    drive(0, 0, 5'd1, 5'd2, 0, 32'h5, 32'h5);
    chk_ctl("R5 equal but not a branch", 5'b11000);
  endtask

  task automatic t_target;
    logic signed [15:0] offs [3] = '{16'sd7, -16'sd3, -16'sd32768};
    logic [31:0] pcs [3] = '{32'h0000_0040, 32'h0000_0100, 32'h0002_0000};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      id_pc_incr = pcs[i];
      id_offset  = offs[i];
      #2;
      chk("R6 branch target", branch_target, pcs[i] + 32'(int'(offs[i]) * 4));
    end
  endtask

  task automatic t_priority;
    drive(1, 5'd6, 5'd6, 5'd2, 1, 32'h9, 32'h9);
    chk_ctl("R7 flush over stall", 5'b11011);
  endtask

  task automatic t_one_bubble;
    drive(1, 5'd2, 5'd2, 5'd5, 0, 1, 2);
    chk_ctl("R9 stall in hazard cycle", 5'b00100);
    drive(0, 5'd0, 5'd2, 5'd5, 0, 1, 2);
    chk_ctl("R9 stall gone after bubble", 5'b11000);
    drive(1, 5'd4, 5'd4, 5'd4, 0, 1, 2);
    drive(1, 5'd4, 5'd4, 5'd4, 0, 1, 2);
    chk_ctl("R9 held hazard keeps stalling", 5'b00100);
  endtask

  initial begin
    rst_n = 0;
    ex_mem_read = 0; ex_rt = 0; id_rs = 0; id_rt = 0; id_branch = 0;
    id_rdata_a = 0; id_rdata_b = 1; id_pc_incr = 0; id_offset = 0;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_load_use();
    t_no_hazard();
    t_zero_reg();
    t_branch();
    t_target();
    t_priority();
    t_one_bubble();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule